// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block chooses, once per clock, which ready instructions leave the issue stage. Each operation class has its own ready queue kept outside the block; the block sees only the head entry of each queue: a valid bit, a 16-bit sequence number, a squash flag and a memory flag. It walks the classes oldest-head first, discards squashed heads without spending issue slots, grants up to `ISSUE_W` live heads, and passes over any class whose functional units are all occupied, counting each such skip.

Functional units are modelled inside the block, one small pool per class. A class can need no unit at all, use fully pipelined units that are free again on the next cycle, or use non-pipelined units that stay occupied for the class latency. Kind and latency per class come from two packed parameter vectors. All strobes leave the block from registers, one cycle after the decision. Because a popped queue cannot present its next head in time, a class that was popped is not considered in the cycle its pop strobe is high.

Top module: `age_issue_select`

## Requirements
- R1: Reset (synchronous, active high) clears all strobes, the issue count and the busy total, and frees every functional unit.
- R2: Eligible heads are visited in ascending age, where head a is older than head b when bit 15 of (seq_a - seq_b) modulo 2^16 is set; ties go to the lower class index.
- R3: No more than `ISSUE_W` grants are raised in one cycle; once that many are granted, younger heads are neither granted nor discarded.
- R4: While `exec_ready` is low at a decision, nothing is granted, popped or discarded.
- R5: A squashed head that is reached in the walk is popped without a grant and does not count toward `ISSUE_W`.
- R6: A head whose class (default class 3, non-pipelined, latency 4) has no free unit is skipped, `busy_total` increases by one per skipped class, and the walk continues with younger classes.
- R7: Class 0 needs no unit and issues whenever the walk reaches it within the width limit.
- R8: For pipelined and single-cycle classes (default classes 1 and 2) the unit-release strobe is raised together with the grant; for a non-pipelined class it is raised LAT-1 cycles after the grant strobe, and the unit can be granted again in that cycle.
- R9: `entry_free` is raised for a granted head only when its memory flag is low.
- R10: A class whose `pop` strobe is high is ignored in that cycle's decision.
- R11: `issue_cnt` equals the number of `grant` bits set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_ready | input | 1 | Downstream stage can accept issued work |
| head_vld | input | NCLS | Per-class head present |
| head_squash | input | NCLS | Per-class head is squashed |
| head_mem | input | NCLS | Per-class head is a memory operation |
| head_seq | input | 16*NCLS | Per-class head sequence number, class c at bits 16c+15:16c |
| grant | output | NCLS | Head of the class issued (registered) |
| pop | output | NCLS | Head of the class consumed, issued or discarded |
| entry_free | output | NCLS | Queue entry released at issue |
| unit_release | output | NCLS | A unit of the class returns to the free pool |
| issue_cnt | output | clog2(ISSUE_W+1) | Grants in this cycle |
| busy_total | output | BUSY_W | Running count of busy-class skips |

## Verification
The assertions assume that live heads lie within half the sequence space of one another, so that the wraparound comparison gives a consistent order, and that a queue removes its head after seeing `pop`. The stimulus keeps every offered set of sequence numbers within a few hundred of each other, including the set that straddles the wrap point, and withdraws or replaces each head after it is popped, except in the one directed case that holds a head on purpose to show the pop mask.

// File: rtl/age_issue_pkg.sv
package age_issue_pkg;
  localparam int SEQ_W = 16;
  typedef logic [SEQ_W-1:0] seq_t;

  localparam logic [1:0] KIND_NONE = 2'd0;
  localparam logic [1:0] KIND_PIPE = 2'd1;
  localparam logic [1:0] KIND_HELD = 2'd2;

  function automatic logic seq_older(seq_t a, seq_t b);
    seq_t d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction
endpackage

// File: rtl/age_issue_rank.sv
module age_issue_rank
  import age_issue_pkg::*;
#(
  parameter int NCLS = 4,
  localparam int IW = (NCLS > 1) ? $clog2(NCLS) : 1
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NCLS-1:0]          elig,
  input  seq_t                     seqs [NCLS],
  output logic [NCLS-1:0][IW-1:0]  ord
);
  logic [IW-1:0] rank [NCLS];

  function automatic logic goes_first(int b, int c);
    if (elig[b] != elig[c]) return elig[b];
    if (!elig[b]) return b < c;
    if (seqs[b] == seqs[c]) return b < c;
    return seq_older(seqs[b], seqs[c]);
  endfunction

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      logic [IW-1:0] n;
      n = '0;
      for (int b = 0; b < NCLS; b++)
        if (b != c && goes_first(b, c)) n = n + IW'(1);
      rank[c] = n;
    end
  end

  always_comb begin
    ord = '0;
    for (int c = 0; c < NCLS; c++) ord[rank[c]] = IW'(c);
  end

  // R2: the first slot of the walk holds an eligible class when any exists
  a_r2_first_slot_eligible: assert property (@(posedge clk) disable iff (rst)
    (|elig) |-> elig[ord[0]]);
endmodule

// File: rtl/age_issue_walk.sv
module age_issue_walk #(
  parameter int NCLS    = 4,
  parameter int ISSUE_W = 2,
  localparam int IW = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int CW = $clog2(ISSUE_W + 1)
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     exec_ready,
  input  logic [NCLS-1:0][IW-1:0]  ord,
  input  logic [NCLS-1:0]          elig,
  input  logic [NCLS-1:0]          squash,
  input  logic [NCLS-1:0]          needs_unit,
  input  logic [NCLS-1:0]          avail,
  output logic [NCLS-1:0]          grant,
  output logic [NCLS-1:0]          discard,
  output logic [NCLS-1:0]          skip,
  output logic [CW-1:0]            cnt
);
  always_comb begin
    grant   = '0;
    discard = '0;
    skip    = '0;
    cnt     = '0;
    for (int r = 0; r < NCLS; r++) begin
      logic [IW-1:0] c;
      c = ord[r];
      if (exec_ready && cnt < CW'(ISSUE_W) && elig[c]) begin
        if (squash[c]) begin
          discard[c] = 1'b1;
        end else if (!needs_unit[c] || avail[c]) begin
          grant[c] = 1'b1;
          cnt      = cnt + CW'(1);
        end else begin
          skip[c] = 1'b1;
        end
      end
    end
  end

  // R3: never more grants than the issue width
  a_r3_width_cap: assert property (@(posedge clk) disable iff (rst)
    $countones(grant) <= ISSUE_W);
  // R5: a discarded head is never also granted
  a_r5_discard_not_grant: assert property (@(posedge clk) disable iff (rst)
    (grant & discard) == '0);
  // R6: a unit-using grant only goes to a class with a free unit
  a_r6_grant_needs_free: assert property (@(posedge clk) disable iff (rst)
    (grant & needs_unit & ~avail) == '0);
endmodule

// File: rtl/age_issue_unit_pool.sv
module age_issue_unit_pool
  import age_issue_pkg::*;
#(
  parameter int         UNITS = 1,
  parameter int         LAT   = 1,
  parameter logic [1:0] KIND  = KIND_PIPE,
  localparam int UW  = (UNITS > 1) ? $clog2(UNITS) : 1,
  localparam int HW  = $clog2(LAT + 1)
)(
  input  logic clk,
  input  logic rst,
  input  logic alloc,
  output logic avail,
  output logic release_o
);
  generate
    if (KIND == KIND_NONE) begin : g_none
      assign avail     = 1'b1;
      assign release_o = 1'b0;
    end else if (KIND == KIND_PIPE || LAT <= 1) begin : g_pipe
      logic rel_q;
      assign avail = 1'b1;
      always_ff @(posedge clk) begin
        if (rst) rel_q <= 1'b0;
        else     rel_q <= alloc;
      end
      assign release_o = rel_q;
    end else begin : g_held
      logic [HW-1:0] hold [UNITS];
      logic [UW-1:0] pick;
      logic          found;
      logic          ending;
      logic          rel_q;

      always_comb begin
        pick   = '0;
        found  = 1'b0;
        ending = 1'b0;
        for (int u = 0; u < UNITS; u++) begin
          if (!found && hold[u] == '0) begin
            pick  = UW'(u);
            found = 1'b1;
          end
          if (hold[u] == HW'(1)) ending = 1'b1;
        end
      end
      assign avail = found;

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int u = 0; u < UNITS; u++) hold[u] <= '0;
          rel_q <= 1'b0;
        end else begin
          rel_q <= ending;
          for (int u = 0; u < UNITS; u++) begin
            if (alloc && found && pick == UW'(u))
              hold[u] <= HW'(LAT - 1);
            else if (hold[u] != '0)
              hold[u] <= hold[u] - HW'(1);
          end
        end
      end
      assign release_o = rel_q;

      // R6: the walk only allocates when a unit is free
      a_r6_alloc_only_free: assert property (@(posedge clk) disable iff (rst)
        alloc |-> found);
    end
  endgenerate
endmodule

// File: rtl/age_issue_select.sv
module age_issue_select
  import age_issue_pkg::*;
#(
  parameter int NCLS    = 4,
  parameter int ISSUE_W = 2,
  parameter int UNITS   = 1,
  parameter int BUSY_W  = 16,
  parameter logic [2*NCLS-1:0] CLASS_KIND = 8'b10_01_01_00,
  parameter logic [4*NCLS-1:0] CLASS_LAT  = 16'h4_3_1_1,
  localparam int IW = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int CW = $clog2(ISSUE_W + 1)
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  exec_ready,
  input  logic [NCLS-1:0]       head_vld,
  input  logic [NCLS-1:0]       head_squash,
  input  logic [NCLS-1:0]       head_mem,
  input  logic [SEQ_W*NCLS-1:0] head_seq,
  output logic [NCLS-1:0]       grant,
  output logic [NCLS-1:0]       pop,
  output logic [NCLS-1:0]       entry_free,
  output logic [NCLS-1:0]       unit_release,
  output logic [CW-1:0]         issue_cnt,
  output logic [BUSY_W-1:0]     busy_total
);
  seq_t                    seqs [NCLS];
  logic [NCLS-1:0]         elig, needs_unit, avail;
  logic [NCLS-1:0]         w_grant, w_discard, w_skip;
  logic [CW-1:0]           w_cnt;
  logic [NCLS-1:0][IW-1:0] ord;

  logic [NCLS-1:0]   grant_q, pop_q, free_q;
  logic [CW-1:0]     cnt_q;
  logic [BUSY_W-1:0] busy_q;

  assign elig = head_vld & ~pop_q;

  genvar g;
  generate
    for (g = 0; g < NCLS; g++) begin : g_cls
      localparam logic [1:0] K = CLASS_KIND[2*g +: 2];
      localparam int         L = int'(CLASS_LAT[4*g +: 4]);
      assign seqs[g]       = head_seq[SEQ_W*g +: SEQ_W];
      assign needs_unit[g] = (K != KIND_NONE);
      age_issue_unit_pool #(.UNITS(UNITS), .LAT(L), .KIND(K)) i_pool (
        .clk(clk), .rst(rst), .alloc(w_grant[g]),
        .avail(avail[g]), .release_o(unit_release[g])
      );
    end
  endgenerate

  age_issue_rank #(.NCLS(NCLS)) i_rank (
    .clk(clk), .rst(rst), .elig(elig), .seqs(seqs), .ord(ord)
  );

  age_issue_walk #(.NCLS(NCLS), .ISSUE_W(ISSUE_W)) i_walk (
    .clk(clk), .rst(rst), .exec_ready(exec_ready), .ord(ord),
    .elig(elig), .squash(head_squash), .needs_unit(needs_unit),
    .avail(avail), .grant(w_grant), .discard(w_discard),
    .skip(w_skip), .cnt(w_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      pop_q   <= '0;
      free_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= '0;
    end else begin
      grant_q <= w_grant;
      pop_q   <= w_grant | w_discard;
      free_q  <= w_grant & ~head_mem;
      cnt_q   <= w_cnt;
      busy_q  <= busy_q + BUSY_W'($countones(w_skip));
    end
  end

  assign grant      = grant_q;
  assign pop        = pop_q;
  assign entry_free = free_q;
  assign issue_cnt  = cnt_q;
  assign busy_total = busy_q;

  // R4: a decision taken while downstream is stalled pops nothing
  a_r4_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    !exec_ready |=> pop_q == '0);
  // R9: entries are freed only for granted heads
  a_r9_free_within_grant: assert property (@(posedge clk) disable iff (rst)
    (free_q & ~grant_q) == '0);
  // R10: a class popped in one cycle is not granted in the next
  a_r10_pop_mask: assert property (@(posedge clk) disable iff (rst)
    (|pop_q) |=> (grant_q & $past(pop_q)) == '0);
  // R11: the count output matches the grant vector
  a_r11_count_match: assert property (@(posedge clk) disable iff (rst)
    issue_cnt == CW'($countones(grant_q)));
endmodule

// File: tb/test_age_issue_select.sv
module test_age_issue_select;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_ready = 1'b0;
  logic [3:0]  head_vld = '0, head_squash = '0, head_mem = '0;
  logic [63:0] head_seq = '0;
  logic [3:0]  grant, pop, entry_free, unit_release;
  logic [1:0]  issue_cnt;
  logic [15:0] busy_total;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  age_issue_select i_age_issue_select (
    .clk(clk), .rst(rst), .exec_ready(exec_ready), .head_vld(head_vld),
    .head_squash(head_squash), .head_mem(head_mem), .head_seq(head_seq),
    .grant(grant), .pop(pop), .entry_free(entry_free),
    .unit_release(unit_release), .issue_cnt(issue_cnt), .busy_total(busy_total)
  );

  typedef struct packed {
    logic [3:0]  vld;
    logic [3:0]  sq;
    logic [3:0]  mem;
    logic [63:0] seq;
    logic        rdy;
    logic [3:0]  e_grant;
    logic [3:0]  e_pop;
    logic [3:0]  e_free;
    logic [1:0]  e_cnt;
  } vec_t;

  // seq packs {class3, class2, class1, class0}
  localparam vec_t VECS [7] = '{
    '{4'b1111, 4'b0000, 4'b0000, {16'd20, 16'd30, 16'd10, 16'd40}, 1'b1, 4'b1010, 4'b1010, 4'b1010, 2'd2},
    '{4'b1111, 4'b0010, 4'b0000, {16'd20, 16'd30, 16'd10, 16'd40}, 1'b1, 4'b1100, 4'b1110, 4'b1100, 2'd2},
    '{4'b1111, 4'b0000, 4'b0000, {16'd20, 16'd30, 16'd10, 16'd40}, 1'b0, 4'b0000, 4'b0000, 4'b0000, 2'd0},
    '{4'b0001, 4'b0000, 4'b0001, {16'd0, 16'd0, 16'd0, 16'd7},     1'b1, 4'b0001, 4'b0001, 4'b0000, 2'd1},
    '{4'b0111, 4'b0000, 4'b0000, {16'd0, 16'hFFF0, 16'h0005, 16'h0100}, 1'b1, 4'b0110, 4'b0110, 4'b0110, 2'd2},
    '{4'b1011, 4'b0000, 4'b1000, {16'd2, 16'd0, 16'd3, 16'd1},     1'b1, 4'b1001, 4'b1001, 4'b0001, 2'd2},
    '{4'b1111, 4'b1111, 4'b0000, {16'd1, 16'd2, 16'd3, 16'd4},     1'b1, 4'b0000, 4'b1111, 4'b0000, 2'd0}
  };
  localparam string VTAG [7] = '{"R2 R3 R9", "R5", "R4", "R7 R9", "R2 wrap", "R2 R9", "R5"};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    head_vld = '0; head_squash = '0; head_mem = '0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic offer(logic [3:0] v, logic [63:0] s);
    head_vld = v; head_squash = '0; head_mem = '0; head_seq = s;
    exec_ready = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 grant after reset", 32'(grant), 0);
    check("R1 pop after reset", 32'(pop), 0);
    check("R1 busy_total after reset", 32'(busy_total), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < 7; k++) begin
      head_vld = VECS[k].vld; head_squash = VECS[k].sq; head_mem = VECS[k].mem;
      head_seq = VECS[k].seq; exec_ready = VECS[k].rdy;
      @(negedge clk);
      check({VTAG[k], " grant"}, 32'(grant), 32'(VECS[k].e_grant));
      check({VTAG[k], " pop"}, 32'(pop), 32'(VECS[k].e_pop));
      check({VTAG[k], " entry_free"}, 32'(entry_free), 32'(VECS[k].e_free));
      check({"R11 ", VTAG[k], " issue_cnt"}, 32'(issue_cnt), 32'(VECS[k].e_cnt));
      idle(4);
    end
    check("R6 no skips in vector table", 32'(busy_total), 0);

    // R6 / R8: non-pipelined class 3 held for 4 cycles
    offer(4'b1000, {16'd5, 48'd0});
    @(negedge clk);
    check("R6 first class3 grant", 32'(grant), 32'b1000);
    idle(1);
    offer(4'b1010, {16'd6, 16'd0, 16'd7, 16'd0});
    @(negedge clk);
    check("R6 busy class3 skipped, class1 issues", 32'(grant), 32'b0010);
    check("R6 busy class3 not popped", 32'(pop), 32'b0010);
    check("R6 busy_total incremented", 32'(busy_total), 1);
    check("R8 pipelined release with grant", 32'(unit_release), 32'b0010);
    idle(1);
    check("R8 held release LAT-1 after grant", 32'(unit_release), 32'b1000);
    offer(4'b1000, {16'd8, 48'd0});
    @(negedge clk);
    check("R8 class3 grantable at release", 32'(grant), 32'b1000);
    idle(4);

    // R10: held head is masked in the cycle its pop is visible
    offer(4'b0010, {32'd0, 16'd9, 16'd0});
    @(negedge clk);
    check("R10 first grant", 32'(grant), 32'b0010);
    @(negedge clk);
    check("R10 masked while pop high", 32'(grant), 32'b0000);
    @(negedge clk);
    check("R10 grant after mask", 32'(grant), 32'b0010);
    idle(4);

    // R1: reset mid-run frees the held unit and clears the busy total
    offer(4'b1000, {16'd20, 48'd0});
    @(negedge clk);
    idle(0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 grant cleared by reset", 32'(grant), 0);
    check("R1 busy_total cleared", 32'(busy_total), 0);
    rst = 1'b0;
    offer(4'b1000, {16'd21, 48'd0});
    @(negedge clk);
    check("R1 unit freed by reset", 32'(grant), 32'b1000);
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule